// File: doc/BRIEF.md
# Four-Entry Instruction Translation Buffer with Pairwise Recency Replacement

This block is a small, fully associative instruction address translation buffer with four entries. A fetch lookup presents a virtual address, an address-space identifier and a flag that says whether the identifier must take part in the match. All four entries are compared in parallel. Each entry carries its own page size, so the compare ignores the address bits that fall inside the page. An entry marked shared matches any identifier. The outcome is registered and appears one cycle later as a hit with the physical address and the entry flags, as a miss, or as a multi-hit when more than one entry matches.

Replacement is decided by six pairwise recency bits, one for each pair of entries. A single hit marks the hit entry as the newest. A miss or a multi-hit leaves the recency state alone. When the surrounding logic has fetched a translation from the larger unified buffer, it presents that entry on the refill port. The refill writes the entry that the recency state names as oldest, marks it newest, and keeps only the flag bits that matter for instruction fetch. The victim index is available at all times, so the refill source can see where the entry will land.

Top module: `itlb4_lru`

## Requirements
- R1: After a synchronous active-low reset, `lru_state` is 0, `rsp_valid` is low, and every entry is invalid, so any lookup misses.
- R2: An entry matches when its valid flag (bit 8) is set, and its shared flag (bit 1) is set or `lk_use_asid` is low or its identifier equals `lk_asid`, and its page number equals `lk_addr[31:10]` on the bits the page size leaves. The size code is {flag bit 7, flag bit 4}: 00 is 1 KiB, 01 is 4 KiB, 10 is 64 KiB, 11 is 1 MiB. Exactly one match gives `rsp_hit` with `rsp_index` set to that entry. No match gives `rsp_miss`.
- R3: On a hit, `rsp_paddr` takes the entry's physical page (`{3'b0, ppn, 10'b0}`) above the page size and the lookup address below it.
- R4: When two or more entries match, `rsp_multi` is high and `rsp_hit` is low.
- R5: A single hit updates `lru_state` by entry: entry 0 gives s & 0x07, entry 1 gives (s & 0x19) | 0x20, entry 2 gives (s & 0x3E) | 0x14, entry 3 gives s | 0x0B.
- R6: `rf_victim` is entry 0 if (s & 0x38) == 0x38, else entry 1 if (s & 0x26) == 0x06, else entry 2 if (s & 0x15) == 0x01, else entry 3. From reset, refills therefore fill entries 3, 2, 1, 0 in turn.
- R7: A refill writes the page number, identifier and physical page into the victim entry unchanged, and its flags ANDed with 0x1DA. It updates `lru_state` as a hit on the victim would.
- R8: A lookup that misses or multi-hits, and an idle cycle, leave `lru_state` unchanged.
- R9: When `rf_valid` and `lk_valid` are high in the same cycle, the refill is carried out and the lookup is dropped. No response follows, and the lookup has no effect on the recency state.
- R10: A lookup accepted at a clock edge raises `rsp_valid` in the following cycle, with exactly one of `rsp_hit`, `rsp_miss` and `rsp_multi` set. When there is no hit, `rsp_index`, `rsp_paddr` and `rsp_flags` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Virtual fetch address |
| lk_asid | input | 8 | Address-space identifier of the lookup |
| lk_use_asid | input | 1 | Identifier must match on non-shared entries |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | 22 | Refill virtual page number (address bits 31:10) |
| rf_asid | input | 8 | Refill identifier |
| rf_ppn | input | 19 | Refill physical page number (physical bits 28:10) |
| rf_flags | input | 9 | Refill flags as held in the unified buffer |
| rf_victim | output | 2 | Entry that the next refill will overwrite |
| lru_state | output | 6 | Pairwise recency bits |
| rsp_valid | output | 1 | Registered response present |
| rsp_hit | output | 1 | Exactly one entry matched |
| rsp_miss | output | 1 | No entry matched |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_index | output | 2 | Matching entry on a hit |
| rsp_paddr | output | 32 | Translated address on a hit |
| rsp_flags | output | 9 | Stored flags of the hit entry |

## Verification
The assertion that a just-touched entry never becomes the victim depends on the recency bits always describing a consistent order. That holds only because the state leaves reset at 0, which is a valid order, and afterwards changes only through the four update masks. The bench never forces the state, so this stays true. The response assertions expect every control input to be a defined 0 or 1 at each clock edge. The stimulus drives all inputs to known values on the falling edge and holds them through the rising edge. Simultaneous refill and lookup are produced on purpose, because the block defines which one wins.

// File: rtl/itlb_pkg.sv
// Package itlb_pkg
// Shared widths, flag bit positions, entry type and page-size decode for the
// four-entry instruction translation buffer. Assumes a 32-bit virtual address,
// a 1 KiB minimum page and a 29-bit physical address space.
package itlb_pkg;
    localparam int unsigned VA_W       = 32;
    localparam int unsigned PAGE_SHIFT = 10;
    localparam int unsigned VPN_W      = VA_W - PAGE_SHIFT;
    localparam int unsigned PPN_W      = 19;
    localparam int unsigned ASID_W     = 8;
    localparam int unsigned FLAG_W     = 9;
    localparam int unsigned ENTRIES    = 4;
    localparam int unsigned IDX_W      = $clog2(ENTRIES);
    localparam int unsigned LRU_W      = ENTRIES * (ENTRIES - 1) / 2;

    localparam int unsigned FB_VALID   = 8;
    localparam int unsigned FB_SZ_HI   = 7;
    localparam int unsigned FB_SZ_LO   = 4;
    localparam int unsigned FB_SHARED  = 1;

    // Flag bits an instruction-side entry keeps from a refill
    localparam logic [FLAG_W-1:0] KEEP_FLAGS = 9'h1DA;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        logic [FLAG_W-1:0] flags;
    } entry_t;

    // Page-number compare mask from the two size bits of a flag word
    function automatic logic [VPN_W-1:0] page_mask(input logic [FLAG_W-1:0] f);
        logic [VPN_W-1:0] m;
        case ({f[FB_SZ_HI], f[FB_SZ_LO]})
            2'b00:   m = {VPN_W{1'b1}};
            2'b01:   m = {VPN_W{1'b1}} << 2;
            2'b10:   m = {VPN_W{1'b1}} << 6;
            default: m = {VPN_W{1'b1}} << 10;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/itlb_lru.sv
// Module itlb_lru
// Holds the six pairwise recency bits for four entries, applies the fixed
// AND/OR update of the touched entry, and names the oldest entry as victim.
// Assumes at most one touch per cycle; the state changes only through a touch.
module itlb_lru
    import itlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [LRU_W-1:0] state,
    output logic [IDX_W-1:0] victim
);
    logic [LRU_W-1:0] state_next;

    // Next state: mark the touched entry newest against the other three
    always_comb begin
        case (touch_idx)
            2'd0:    state_next = state & 6'h07;
            2'd1:    state_next = (state & 6'h19) | 6'h20;
            2'd2:    state_next = (state & 6'h3E) | 6'h14;
            default: state_next = state | 6'h0B;
        endcase
    end

    // State register, cleared by reset, written only on a touch
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= '0;
        else if (touch)
            state <= state_next;
    end

    // Victim: first entry in priority order that every other entry is newer than
    always_comb begin
        if ((state & 6'h38) == 6'h38)
            victim = 2'd0;
        else if ((state & 6'h26) == 6'h06)
            victim = 2'd1;
        else if ((state & 6'h15) == 6'h01)
            victim = 2'd2;
        else
            victim = 2'd3;
    end

    // The entry just touched is never the next one replaced
    assert_victim_fresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> (victim != $past(touch_idx)));

    // Without a touch the recency state holds
    assert_state_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !touch |=> $stable(state));
endmodule

// File: rtl/itlb_store.sv
// Module itlb_store
// Register file of the four entries. A write lands in one indexed entry and
// keeps only the instruction-side flag subset. Reset invalidates all entries.
module itlb_store
    import itlb_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  entry_t                    wr_data,
    output entry_t [ENTRIES-1:0]      entries
);
    // Entry registers: clear on reset, overwrite the indexed entry on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entries <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    entries[i].vpn   <= wr_data.vpn;
                    entries[i].asid  <= wr_data.asid;
                    entries[i].ppn   <= wr_data.ppn;
                    entries[i].flags <= wr_data.flags & KEEP_FLAGS;
                end
            end
        end
    end

    logic [FLAG_W-1:0] stray_flags;

    // Collect any held flag bit outside the kept subset
    always_comb begin
        stray_flags = '0;
        for (int i = 0; i < ENTRIES; i++)
            stray_flags = stray_flags | (entries[i].flags & ~KEEP_FLAGS);
    end

    // Stored entries only ever hold the instruction-side flag subset
    assert_flag_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stray_flags == '0);
endmodule

// File: rtl/itlb_match.sv
// Module itlb_match
// Parallel compare of one lookup against every entry using per-entry page
// masks and identifier/shared rules, followed by a match count that separates
// single hit from multi-hit. Purely combinational.
module itlb_match
    import itlb_pkg::*;
(
    input  entry_t [ENTRIES-1:0] entries,
    input  logic [VPN_W-1:0]     vpn,
    input  logic [ASID_W-1:0]    asid,
    input  logic                 use_asid,
    output logic                 single,
    output logic                 multi,
    output logic [IDX_W-1:0]     hit_idx
);
    logic [ENTRIES-1:0] hit_vec;

    // One comparator per entry
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
        logic id_ok;
        logic page_ok;
        assign id_ok   = entries[gi].flags[FB_SHARED] | ~use_asid |
                         (entries[gi].asid == asid);
        assign page_ok = ((entries[gi].vpn ^ vpn) & page_mask(entries[gi].flags)) == '0;
        assign hit_vec[gi] = entries[gi].flags[FB_VALID] & id_ok & page_ok;
    end

    logic [IDX_W:0] hit_cnt;

    // Count matches and encode the matching index
    always_comb begin
        hit_cnt = '0;
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                hit_cnt = hit_cnt + 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
        single = (hit_cnt == 1);
        multi  = (hit_cnt > 1);
    end
endmodule

// File: rtl/itlb4_lru.sv
// Module itlb4_lru
// Four-entry fully associative instruction translation buffer. Lookups give a
// registered hit/miss/multi-hit response one cycle later; refills overwrite
// the least recently used entry. Assumes the caller normally never issues a
// refill and a lookup together; if it does, the refill wins.
module itlb4_lru
    import itlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [31:0]       lk_addr,
    input  logic [7:0]        lk_asid,
    input  logic              lk_use_asid,
    input  logic              rf_valid,
    input  logic [21:0]       rf_vpn,
    input  logic [7:0]        rf_asid,
    input  logic [18:0]       rf_ppn,
    input  logic [8:0]        rf_flags,
    output logic [1:0]        rf_victim,
    output logic [5:0]        lru_state,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_multi,
    output logic [1:0]        rsp_index,
    output logic [31:0]       rsp_paddr,
    output logic [8:0]        rsp_flags
);
    entry_t [ENTRIES-1:0] entries;
    entry_t               wr_data;
    logic                 lk_go;
    logic                 hit_single;
    logic                 hit_multi;
    logic [IDX_W-1:0]     hit_idx;
    logic                 touch;
    logic [IDX_W-1:0]     touch_idx;
    entry_t               hit_e;
    logic [VPN_W-1:0]     hit_mask;
    logic [VPN_W-1:0]     hit_pfn;

    // Refill has priority; a lookup only proceeds alone
    assign lk_go     = lk_valid & ~rf_valid;
    assign touch     = rf_valid | (lk_go & hit_single);
    assign touch_idx = rf_valid ? rf_victim : hit_idx;
    assign wr_data   = '{vpn: rf_vpn, asid: rf_asid, ppn: rf_ppn, flags: rf_flags};

    itlb_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rf_valid),
        .wr_idx  (rf_victim),
        .wr_data (wr_data),
        .entries (entries)
    );

    itlb_match u_match (
        .entries  (entries),
        .vpn      (lk_addr[VA_W-1:PAGE_SHIFT]),
        .asid     (lk_asid),
        .use_asid (lk_use_asid),
        .single   (hit_single),
        .multi    (hit_multi),
        .hit_idx  (hit_idx)
    );

    itlb_lru u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (touch),
        .touch_idx (touch_idx),
        .state     (lru_state),
        .victim    (rf_victim)
    );

    // Physical address: page from the entry above the page size, offset below
    always_comb begin
        hit_e    = entries[hit_idx];
        hit_mask = page_mask(hit_e.flags);
        hit_pfn  = ({{(VPN_W - PPN_W){1'b0}}, hit_e.ppn} & hit_mask) |
                   (lk_addr[VA_W-1:PAGE_SHIFT] & ~hit_mask);
    end

    // Response register, one cycle after the accepted lookup
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_multi <= 1'b0;
            rsp_index <= '0;
            rsp_paddr <= '0;
            rsp_flags <= '0;
        end else begin
            rsp_valid <= lk_go;
            rsp_hit   <= lk_go & hit_single;
            rsp_miss  <= lk_go & ~hit_single & ~hit_multi;
            rsp_multi <= lk_go & hit_multi;
            if (lk_go && hit_single) begin
                rsp_index <= hit_idx;
                rsp_paddr <= {hit_pfn, lk_addr[PAGE_SHIFT-1:0]};
                rsp_flags <= hit_e.flags;
            end else begin
                rsp_index <= '0;
                rsp_paddr <= '0;
                rsp_flags <= '0;
            end
        end
    end

    // A response carries exactly one outcome
    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_multi}) == 1));

    // A lookup colliding with a refill yields no response
    assert_refill_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && lk_valid) |=> !rsp_valid);

    // The page offset passes through untranslated
    assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_paddr[PAGE_SHIFT-1:0] == $past(lk_addr[PAGE_SHIFT-1:0])));

    // A hit always comes from a valid entry
    assert_hit_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_flags[FB_VALID]);

    // A lookup without a single match leaves recency untouched
    assert_miss_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_go && !hit_single) |=> $stable(lru_state));
endmodule

// File: tb/test_itlb4_lru.sv
// Bench for itlb4_lru: a behavioural reference model (recency kept as a queue)
// is updated on each rising edge and compared on each falling edge.
module test_itlb4_lru;
    import itlb_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_use_asid = 1'b0, rf_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic [7:0]  lk_asid = '0, rf_asid = '0;
    logic [21:0] rf_vpn = '0;
    logic [18:0] rf_ppn = '0;
    logic [8:0]  rf_flags = '0;
    logic [1:0]  rf_victim, rsp_index;
    logic [5:0]  lru_state;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_multi;
    logic [31:0] rsp_paddr;
    logic [8:0]  rsp_flags;

    always #4 clk = ~clk;

    itlb4_lru i_itlb4_lru (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_asid(lk_asid), .lk_use_asid(lk_use_asid), .rf_valid(rf_valid),
        .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_ppn(rf_ppn), .rf_flags(rf_flags),
        .rf_victim(rf_victim), .lru_state(lru_state), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_multi(rsp_multi),
        .rsp_index(rsp_index), .rsp_paddr(rsp_paddr), .rsp_flags(rsp_flags)
    );

    int total = 0, fails = 0;
    bit done = 0, started = 0, last_refill = 0;

    // Reference model state
    logic [21:0] m_vpn [4];
    logic [7:0]  m_asid [4];
    logic [18:0] m_ppn [4];
    logic [8:0]  m_flags [4];
    int          order[$];
    logic        e_valid, e_hit, e_miss, e_multi;
    logic [1:0]  e_idx;
    logic [31:0] e_paddr;
    logic [8:0]  e_flags;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int page_bits(logic [8:0] f);
        case ({f[7], f[4]})
            2'b00: return 10;
            2'b01: return 12;
            2'b10: return 16;
            default: return 20;
        endcase
    endfunction

    function automatic int rank(int k);
        foreach (order[i]) if (order[i] == k) return i;
        return 99;
    endfunction

    function automatic logic newer(int a, int b);
        return rank(a) < rank(b);
    endfunction

    function automatic logic [5:0] exp_lru();
        return {newer(1,0), newer(2,0), newer(3,0), newer(2,1), newer(3,1), newer(3,2)};
    endfunction

    task automatic touch(int k);
        int r;
        r = rank(k);
        order.delete(r);
        order.push_front(k);
    endtask

    // Model update at each rising edge from the inputs held since the falling edge
    always @(posedge clk) begin
        e_valid = 0; e_hit = 0; e_miss = 0; e_multi = 0;
        e_idx = 0; e_paddr = 0; e_flags = 0; last_refill = 0;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_vpn[i] = 0; m_asid[i] = 0; m_ppn[i] = 0; m_flags[i] = 0;
            end
            order = '{0, 1, 2, 3};
            started = 1;
        end else if (rf_valid) begin
            int v;
            v = order[order.size() - 1];
            m_vpn[v] = rf_vpn; m_asid[v] = rf_asid; m_ppn[v] = rf_ppn;
            m_flags[v] = rf_flags & 9'h1DA;
            touch(v);
            last_refill = 1;
        end else if (lk_valid) begin
            int cnt, which, pb;
            cnt = 0; which = 0;
            for (int i = 0; i < 4; i++) begin
                pb = page_bits(m_flags[i]);
                if (m_flags[i][8] && (m_flags[i][1] || !lk_use_asid || m_asid[i] == lk_asid) &&
                    ((lk_addr >> pb) == ({m_vpn[i], 10'b0} >> pb))) begin
                    cnt++; which = i;
                end
            end
            e_valid = 1;
            if (cnt == 1) begin
                pb = page_bits(m_flags[which]);
                e_hit = 1; e_idx = 2'(which); e_flags = m_flags[which];
                e_paddr = ((({3'b0, m_ppn[which], 10'b0}) >> pb) << pb) |
                          (lk_addr & ((32'h1 << pb) - 1));
                touch(which);
            end else if (cnt == 0) e_miss = 1;
            else e_multi = 1;
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            check(last_refill ? "R7" : "R5", "lru_state", 32'(lru_state), 32'(exp_lru()));
            check("R6", "rf_victim", 32'(rf_victim), 32'(order[order.size() - 1]));
            check("R10", "rsp_valid", 32'(rsp_valid), 32'(e_valid));
            check("R2", "rsp_hit/miss", {30'b0, rsp_hit, rsp_miss}, {30'b0, e_hit, e_miss});
            check("R4", "rsp_multi", 32'(rsp_multi), 32'(e_multi));
            check("R2", "rsp_index", 32'(rsp_index), 32'(e_idx));
            check("R3", "rsp_paddr", rsp_paddr, e_paddr);
            check("R7", "rsp_flags", 32'(rsp_flags), 32'(e_flags));
        end
    end

    task automatic refill(logic [31:0] a, logic [7:0] as, logic [18:0] p, logic [8:0] f);
        rf_valid = 1; rf_vpn = a[31:10]; rf_asid = as; rf_ppn = p; rf_flags = f;
        @(negedge clk);
        rf_valid = 0;
    endtask

    task automatic lookup(logic [31:0] a, logic [7:0] as, logic ua);
        lk_valid = 1; lk_addr = a; lk_asid = as; lk_use_asid = ua;
        @(negedge clk);
        lk_valid = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog run did not complete");
            finish_run();
        end
    end

    initial begin
        logic [5:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R1", "lru after reset", 32'(lru_state), 0);
        check("R1", "rsp_valid after reset", 32'(rsp_valid), 0);
        lookup(32'h0040_0000, 8'd5, 1'b1);
        check("R1", "empty buffer misses", 32'(rsp_miss), 1);

        // Fill: entries 3,2,1,0 in turn
        check("R6", "first victim", 32'(rf_victim), 3);
        refill(32'h0040_0000, 8'd5, 19'h01234, 9'h175);
        refill(32'h1230_0000, 8'd9, 19'h10000, 9'h182);
        refill(32'h2000_0000, 8'd5, 19'h00C00, 9'h1D0);
        refill(32'h0000_4000, 8'd7, 19'h00055, 9'h108);
        check("R7", "lru after four refills", 32'(lru_state), 0);
        check("R6", "victim after four refills", 32'(rf_victim), 3);

        lookup(32'h0040_0ABC, 8'd5, 1'b1);
        check("R3", "4K paddr", rsp_paddr, 32'h0048_DABC);
        check("R7", "flags reduced", 32'(rsp_flags), 32'h150);
        check("R5", "victim after hit on 3", 32'(rf_victim), 2);
        lookup(32'h0040_0FFF, 8'd5, 1'b1);
        check("R2", "4K last byte hits", 32'(rsp_hit), 1);
        lookup(32'h0040_1000, 8'd5, 1'b1);
        check("R2", "4K next page misses", 32'(rsp_miss), 1);
        lookup(32'h1230_5678, 8'd1, 1'b1);
        check("R2", "shared hit other asid", 32'(rsp_paddr), 32'h0400_5678);
        lookup(32'h1231_0000, 8'd9, 1'b1);
        check("R2", "64K next page misses", 32'(rsp_miss), 1);
        lookup(32'h200A_BCDE, 8'd5, 1'b1);
        check("R3", "1M paddr", rsp_paddr, 32'h003A_BCDE);
        lookup(32'h200A_BCDE, 8'd6, 1'b1);
        check("R2", "asid mismatch misses", 32'(rsp_miss), 1);
        lookup(32'h200A_BCDE, 8'd6, 1'b0);
        check("R2", "asid ignored hits", 32'(rsp_hit), 1);
        lookup(32'h0000_43FF, 8'd7, 1'b1);
        check("R3", "1K paddr", rsp_paddr, 32'h0001_57FF);
        lookup(32'h0000_4400, 8'd7, 1'b1);
        check("R2", "1K next page misses", 32'(rsp_miss), 1);

        // Make entry 1 oldest, then overlap entry 0 with a 4K page
        lookup(32'h0040_0000, 8'd5, 1'b1);
        lookup(32'h1230_0000, 8'd9, 1'b1);
        lookup(32'h0000_4000, 8'd7, 1'b1);
        check("R6", "victim after touching 3,2,0", 32'(rf_victim), 1);
        refill(32'h0000_4000, 8'd7, 19'h00200, 9'h110);
        held = lru_state;
        lookup(32'h0000_4100, 8'd7, 1'b1);
        check("R4", "overlap multi-hit", 32'(rsp_multi), 1);
        check("R8", "lru held on multi-hit", 32'(lru_state), 32'(held));
        lookup(32'h0000_4800, 8'd7, 1'b1);
        check("R3", "larger page alone hits", rsp_paddr, 32'h0008_0800);
        held = lru_state;
        lookup(32'h7000_0000, 8'd7, 1'b1);
        check("R8", "lru held on miss", 32'(lru_state), 32'(held));
        @(negedge clk);
        check("R8", "lru held when idle", 32'(lru_state), 32'(held));

        // Refill without valid flag gives an unmatchable entry
        refill(32'h3000_0000, 8'd7, 19'h00001, 9'h010);
        lookup(32'h3000_0000, 8'd7, 1'b0);
        check("R2", "invalid entry misses", 32'(rsp_miss), 1);

        // Collision: refill wins, lookup dropped
        rf_valid = 1; rf_vpn = 22'h3F_0000; rf_asid = 8'd2; rf_ppn = 19'h00100; rf_flags = 9'h100;
        lk_valid = 1; lk_addr = 32'h0000_4800; lk_asid = 8'd7; lk_use_asid = 1;
        @(negedge clk);
        rf_valid = 0; lk_valid = 0;
        check("R9", "no response on collision", 32'(rsp_valid), 0);

        // Random traffic over a small, overlapping address window
        for (int n = 0; n < 3000; n++) begin
            int sel;
            logic [31:0] a;
            sel = $urandom_range(0, 99);
            a = 32'h0010_0000 | ($urandom & 32'h000F_3FFF);
            rf_valid = 0; lk_valid = 0;
            if (sel < 15 || sel >= 95) begin
                rf_valid = 1; rf_vpn = a[31:10]; rf_asid = 8'($urandom_range(1, 2));
                rf_ppn = 19'($urandom); rf_flags = 9'($urandom) | (sel[0] ? 9'h100 : 9'h0);
            end
            if (sel >= 15) begin
                lk_valid = (sel < 80) || (sel >= 95); lk_addr = a;
                lk_asid = 8'($urandom_range(1, 2)); lk_use_asid = 1'($urandom);
            end
            @(negedge clk);
        end
        rf_valid = 0; lk_valid = 0;
        @(negedge clk);
        finish_run();
    end
endmodule